// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the raster timing for a panel that takes two pixels on every clock: one odd-column pixel and one even-column pixel. Two free-running counters track the position in the line and in the frame. The block derives horizontal sync, vertical sync and data enable from these counters. During active video it requests a pixel pair from a pixel source and passes the returned pair on to the downstream link packer, one odd word and one even word per clock, in step with the control signals.

Each line holds 960 active clocks, so a 1920-pixel line is covered. The line is 1288 clocks long. Active video begins 268 clocks after the start of horizontal sync, and a 60-clock front porch closes the line. The frame is 748 lines long. Active lines begin 25 lines after the start of vertical sync, and a front porch of exactly 3 lines closes the frame. The sync widths and the sync polarities are parameters.

The request side works as follows. On an active clock the block raises `req` and drives the column and line of the wanted pair. The source answers in the same cycle on `rsp_odd` and `rsp_even`. The block registers both the answer and the timing signals, so its outputs follow the request by exactly one clock.

Top module: `raster_pair_gen`

## Requirements
- R1: The horizontal position counts 0 to H_LEAD+H_ACTIVE+H_FRONT-1 and then returns to 0, so every line lasts exactly that many clocks.
- R2: The vertical position advances once per line and wraps after V_LEAD+V_ACTIVE+3 lines. The front porch is always 3 lines.
- R3: `hsync` is at its asserted level during the first H_PULSE clocks of each line and at the opposite level otherwise. The asserted level is 1 when HS_HIGH=1 and 0 when HS_HIGH=0.
- R4: `vsync` is at its asserted level during the first V_PULSE whole lines of each frame and at the opposite level otherwise. The asserted level is 1 when VS_HIGH=1 and 0 when VS_HIGH=0.
- R5: `de` is 1 only for positions whose horizontal index lies in [H_LEAD, H_LEAD+H_ACTIVE) and whose line index lies in [V_LEAD, V_LEAD+V_ACTIVE).
- R6: `req` is 1 at exactly the active positions of the current counter state. On active clock k of a line, `req_col` = 2k, which is the odd pixel's 0-based column; the even pixel is column 2k+1. `req_line` gives the active line index. Both are 0 while `req` is 0.
- R7: `hsync`, `vsync`, `de`, `odd_pix` and `even_pix` are registered and show the position of the previous clock. When `de` is 1, `odd_pix` and `even_pix` equal the `rsp_odd` and `rsp_even` values presented during that previous clock.
- R8: `odd_pix` and `even_pix` are 0 whenever `de` is 0, whatever the source drives.
- R9: A synchronous active-high reset returns both counters to position 0. While reset is held, syncs are at their deasserted levels, `de` is 0 and the pixel words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous reset, active high |
| rsp_odd | input | PIX_W | Odd-column pixel returned for the current request |
| rsp_even | input | PIX_W | Even-column pixel returned for the current request |
| req | output | 1 | Pixel pair wanted this cycle |
| req_col | output | COL_W | Column of the odd pixel of the wanted pair |
| req_line | output | LINE_W | Active line index of the wanted pair |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| odd_pix | output | PIX_W | Odd-column pixel word to the packer |
| even_pix | output | PIX_W | Even-column pixel word to the packer |

## Verification
The bench builds the block with a 6-clock active line, a 5-clock lead, a 3-clock front porch and a 2-clock horizontal pulse. Vertically it uses 4 active lines, a 3-line lead and a 1-line pulse. The result is a 14x10 frame of 140 clocks, so every wrap, porch edge and sync edge is reached many times, over several whole frames. Horizontal sync is built active low and vertical sync active high, which puts both polarity branches under test in one build. While `req` is low the bench's source drives all-ones, so any leak of unrequested data into the pixel words becomes visible.

// File: rtl/raster_pair_gen.sv
module raster_pair_gen #(
  parameter int H_ACTIVE = 960,
  parameter int H_FRONT  = 60,
  parameter int H_LEAD   = 268,
  parameter int H_PULSE  = 32,
  parameter int V_ACTIVE = 720,
  parameter int V_LEAD   = 25,
  parameter int V_PULSE  = 4,
  parameter bit HS_HIGH  = 1'b0,
  parameter bit VS_HIGH  = 1'b0,
  parameter int PIX_W    = 24,
  localparam int V_FRONT = 3,
  localparam int H_TOTAL = H_LEAD + H_ACTIVE + H_FRONT,
  localparam int V_TOTAL = V_LEAD + V_ACTIVE + V_FRONT,
  localparam int HC_W    = $clog2(H_TOTAL),
  localparam int VC_W    = $clog2(V_TOTAL),
  localparam int COL_W   = $clog2(2 * H_ACTIVE),
  localparam int LINE_W  = $clog2(V_ACTIVE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  rsp_odd,
  input  logic [PIX_W-1:0]  rsp_even,
  output logic              req,
  output logic [COL_W-1:0]  req_col,
  output logic [LINE_W-1:0] req_line,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  odd_pix,
  output logic [PIX_W-1:0]  even_pix
);

  logic [HC_W-1:0] hcnt;
  logic [VC_W-1:0] vcnt;
  logic h_end, v_end, h_act, v_act, hs_on, vs_on;
  logic [HC_W-1:0] hoff;
  logic [VC_W-1:0] voff;

  assign h_end = (hcnt == HC_W'(H_TOTAL - 1));
  assign v_end = (vcnt == VC_W'(V_TOTAL - 1));
  assign h_act = (hcnt >= HC_W'(H_LEAD)) && (hcnt < HC_W'(H_LEAD + H_ACTIVE));
  assign v_act = (vcnt >= VC_W'(V_LEAD)) && (vcnt < VC_W'(V_LEAD + V_ACTIVE));
  assign hs_on = (hcnt < HC_W'(H_PULSE));
  assign vs_on = (vcnt < VC_W'(V_PULSE));
  assign hoff  = hcnt - HC_W'(H_LEAD);
  assign voff  = vcnt - VC_W'(V_LEAD);

  assign req      = h_act & v_act;
  assign req_col  = req ? COL_W'({hoff, 1'b0}) : '0;
  assign req_line = req ? LINE_W'(voff) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_end ? '0 : hcnt + 1'b1;
      if (h_end) vcnt <= v_end ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync    <= ~HS_HIGH;
      vsync    <= ~VS_HIGH;
      de       <= 1'b0;
      odd_pix  <= '0;
      even_pix <= '0;
    end else begin
      hsync    <= hs_on ? HS_HIGH : ~HS_HIGH;
      vsync    <= vs_on ? VS_HIGH : ~VS_HIGH;
      de       <= req;
      odd_pix  <= req ? rsp_odd : '0;
      even_pix <= req ? rsp_even : '0;
    end
  end

  p_hwrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hcnt == HC_W'(H_TOTAL - 1)) |=> (hcnt == '0));

  p_vwrap_r2: assert property (@(posedge clk) disable iff (rst)
    (hcnt == HC_W'(H_TOTAL - 1) && vcnt == VC_W'(V_TOTAL - 1)) |=> (vcnt == '0));

  p_de_follows_req_r5: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(req));

  p_col_even_r6: assert property (@(posedge clk) disable iff (rst)
    req |-> (req_col[0] == 1'b0));

  p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |-> (req_col == $past(req_col) + COL_W'(2)));

  p_pix_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !de |-> (odd_pix == '0 && even_pix == '0));

endmodule

// File: tb/raster_pair_gen_test.sv
module raster_pair_gen_test;
  localparam int HA = 6, HF = 3, HL = 5, HP = 2;
  localparam int VA = 4, VL = 3, VP = 1;
  localparam int HT = HL + HA + HF;
  localparam int VT = VL + VA + 3;
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {16'd1,   4'b0100}, {16'd3,   4'b1100}, {16'd14,  4'b1100}, {16'd15,  4'b0000},
    {16'd47,  4'b1001}, {16'd48,  4'b1011}, {16'd53,  4'b1010}, {16'd54,  4'b1000},
    {16'd95,  4'b1010}, {16'd103, 4'b1000}, {16'd140, 4'b1000}, {16'd141, 4'b0100}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] rsp_odd, rsp_even, odd_pix, even_pix;
  logic req, hsync, vsync, de;
  logic [3:0] req_col;
  logic [1:0] req_line;
  int checks = 0, fails = 0, c = 0;

  always #10 clk = ~clk;

  assign rsp_odd  = req ? {8'h3C, 6'd0, req_line, 4'd0, req_col} : 24'hFFFFFF;
  assign rsp_even = req ? {8'hC3, 6'd0, req_line, 4'd0, req_col + 4'd1} : 24'hFFFFFF;

  raster_pair_gen #(.H_ACTIVE(HA), .H_FRONT(HF), .H_LEAD(HL), .H_PULSE(HP),
    .V_ACTIVE(VA), .V_LEAD(VL), .V_PULSE(VP), .HS_HIGH(1'b0), .VS_HIGH(1'b1),
    .PIX_W(24)) uut (
    .clk(clk), .rst(rst), .rsp_odd(rsp_odd), .rsp_even(rsp_even), .req(req),
    .req_col(req_col), .req_line(req_line), .hsync(hsync), .vsync(vsync),
    .de(de), .odd_pix(odd_pix), .even_pix(even_pix));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at c=%0d", tag, act, exp, c);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst) c++;
    @(negedge clk);
  endtask

  function automatic int hpos(int p); return p % HT; endfunction
  function automatic int vpos(int p); return (p / HT) % VT; endfunction
  function automatic bit act(int p);
    return hpos(p) >= HL && hpos(p) < HL + HA && vpos(p) >= VL && vpos(p) < VL + VA;
  endfunction

  task automatic sweep_check();
    int p = c - 1;
    bit a = act(p);
    logic [23:0] eo = a ? {8'h3C, 6'd0, 2'(vpos(p) - VL), 4'd0, 4'(2 * (hpos(p) - HL))} : 24'd0;
    logic [23:0] ee = a ? {8'hC3, 6'd0, 2'(vpos(p) - VL), 4'd0, 4'(2 * (hpos(p) - HL) + 1)} : 24'd0;
    bit ehs = (hpos(p) < HP) ? 1'b0 : 1'b1;
    bit evs = (vpos(p) < VP) ? 1'b1 : 1'b0;
    bit ra = act(c);
    chk(hsync == ehs, "R3 hsync", hsync, ehs);
    chk(vsync == evs, "R4 vsync", vsync, evs);
    chk(de == a, "R5 de", de, a);
    chk(req == ra, "R6 req", req, ra);
    chk(req_col == (ra ? 4'(2 * (hpos(c) - HL)) : 4'd0), "R6 req_col", req_col,
        ra ? 2 * (hpos(c) - HL) : 0);
    chk(req_line == (ra ? 2'(vpos(c) - VL) : 2'd0), "R6 req_line", req_line,
        ra ? vpos(c) - VL : 0);
    chk(odd_pix == eo, a ? "R7 odd_pix" : "R8 odd_pix", odd_pix, eo);
    chk(even_pix == ee, a ? "R7 even_pix" : "R8 even_pix", even_pix, ee);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hsync == 1'b1, "R9 hsync idle", hsync, 1);
    chk(vsync == 1'b0, "R9 vsync idle", vsync, 0);
    chk(de == 1'b0, "R9 de", de, 0);
    chk(odd_pix == 24'd0 && even_pix == 24'd0, "R9 pixels", odd_pix, 0);
    chk(req == 1'b0, "R9 req", req, 0);
    rst = 1'b0;
    // table walk: R1 and R2 wrap at c=141, R3/R4/R5/R6 at edges
    for (int i = 0; i < NV; i++) begin
      while (c < int'(VEC[i][19:4])) step();
      chk(hsync == VEC[i][3], "R3 table hsync", hsync, VEC[i][3]);
      chk(vsync == VEC[i][2], "R4 table vsync", vsync, VEC[i][2]);
      chk(de == VEC[i][1], "R5 table de", de, VEC[i][1]);
      chk(req == VEC[i][0], (i >= 10) ? "R1 R2 table wrap req" : "R6 table req", req, VEC[i][0]);
    end
    // three more frames against the model
    for (int n = 0; n < 3 * HT * VT; n++) begin
      step();
      sweep_check();
    end
    // mid-frame reset restarts the raster
    while (!act(c)) step();
    rst = 1'b1;
    step();
    chk(de == 1'b0 && hsync == 1'b1 && vsync == 1'b0, "R9 reset outputs", {de, hsync, vsync}, 3'b010);
    chk(req == 1'b0, "R9 reset req", req, 0);
    rst = 1'b0;
    c = 0;
    for (int n = 0; n < HT * VT + 5; n++) begin
      step();
      sweep_check();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule